// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests on a set of numbered levels. Level 0 has the highest priority, and priority falls as the index rises. A request sets a latch bit. A latched level is eligible when its mask bit and the global enable both allow it. The block keeps one in-service bit per level as a stack-like bitmask. It vectors the core to a new routine with a one-cycle take strobe that carries the chosen level number. A return strobe from the core ends the routine that has the highest priority among those in service.

A configuration input enables same-level re-entry. When it is on, a level may interrupt its own routine, but only if all of these hold:
- the level is marked as a core or software-raised source;
- the core reports that its return address has been saved;
- the nesting count of that level has not reached its limit.

A nesting counter for each level makes sure that only the outermost return clears the in-service bit. While the active routine is a re-entered one, a status output is high.

Top module: `nic_top`

## Requirements
- R1: After reset the latch bits, the in-service bits, the take strobe and the self-nest status are all zero.
- R2: When several latched levels are eligible, the lowest index is taken. A take is a single-cycle strobe on `takeOut`, with the level on `vecLevel`. For a request sampled at clock edge k, the take is visible after edge k+1.
- R3: A level is taken only if its index is lower than every level in service, unless R7 applies. A level of lower priority stays latched until it becomes the highest pending level.
- R4: On a take, the level's latch bit clears and its in-service bit sets. In-service bit i stands for level i, so level 7 alone in service reads 0x0080.
- R5: With self-nesting off, a request at the level in service stays latched. It is taken once a return has cleared that level.
- R6: A latched level whose mask bit is 0, or any latched level while the global enable is 0, is held and not taken. It is taken once both enables are 1.
- R7: With self-nesting on, a request at the level in service is taken again only if `coreSrc` marks that level, `retSaved` is 1 and the global enable is 1. Such an entry sets `selfNestFlag`.
- R8: A return from a re-entered routine decrements that level's nesting count and leaves the in-service bit set. Only the return at count zero clears the bit. `selfNestFlag` equals (count of the lowest in-service level is non-zero).
- R9: A level not marked in `coreSrc` never re-enters itself, whatever the configuration.
- R10: The nesting count of a level saturates at NEST_MAX. A further same-level request then stays latched until a return lowers the count.
- R11: In a cycle with `rtiStrobe` high, no take occurs. A level that becomes eligible in that cycle is taken on the next edge.
- R12: A return clears the lowest-index in-service bit, subject to R8. A return with nothing in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_LEVELS | Request lines, one per level, sampled every edge |
| maskIn | input | NUM_LEVELS | Per-level enable, 1 allows a take |
| coreSrc | input | NUM_LEVELS | 1 marks a core or software-raised level that may re-enter |
| globalEn | input | 1 | Global interrupt enable |
| selfNestEn | input | 1 | Enables same-level re-entry |
| retSaved | input | 1 | Core has saved the return address of the active routine |
| rtiStrobe | input | 1 | Return from the active routine |
| takeOut | output | 1 | One-cycle strobe to vector the core |
| vecLevel | output | LVL_W | Level of the latest take |
| latchOut | output | NUM_LEVELS | Latched requests not yet taken |
| pendOut | output | NUM_LEVELS | Levels in service |
| selfNestFlag | output | 1 | Active routine is a re-entered one |

## Verification
The bench builds the block with 16 levels and NEST_MAX set to 2. With that small limit, the nesting cap is reached after only two re-entries, so saturation, the blocked third request and its release after one return all fit in a short run. Sixteen levels with only levels 0 to 7 marked as core sources put a non-core level (10) within reach. That exercises the refusal of re-entry next to re-entry that is allowed.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic take;      // enter a routine at takeLvl
    logic selfNest;  // the entry is a same-level re-entry
    logic rti;       // return from the routine at svcLvl
  } ctrlStrobeT;
endpackage

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
  parameter int WIDTH = 16,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nic_control.sv
module nic_control
  import nic_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] latchQ,
  input  logic [NUM_LEVELS-1:0] pendQ,
  input  logic [NUM_LEVELS-1:0] nestFull,
  input  logic [NUM_LEVELS-1:0] maskIn,
  input  logic [NUM_LEVELS-1:0] coreSrc,
  input  logic                  globalEn,
  input  logic                  selfNestEn,
  input  logic                  retSaved,
  input  logic                  rtiStrobe,
  output ctrlStrobeT            strobes,
  output logic [LVL_W-1:0]      takeLvl,
  output logic [LVL_W-1:0]      svcLvl,
  output logic                  svcFound
);
  logic [NUM_LEVELS-1:0] eligible;
  logic                  candFound;
  logic                  higherOk;
  logic                  sameOk;

  assign eligible = latchQ & maskIn & {NUM_LEVELS{globalEn}};

  nic_prio_enc #(.WIDTH(NUM_LEVELS), .IDX_W(LVL_W)) uCandEnc (
    .vecIn(eligible), .found(candFound), .idx(takeLvl)
  );

  nic_prio_enc #(.WIDTH(NUM_LEVELS), .IDX_W(LVL_W)) uSvcEnc (
    .vecIn(pendQ), .found(svcFound), .idx(svcLvl)
  );

  always_comb begin
    higherOk = !svcFound || (takeLvl < svcLvl);
    sameOk   = svcFound && (takeLvl == svcLvl) && selfNestEn &&
               coreSrc[takeLvl] && retSaved && !nestFull[takeLvl];
    strobes.take     = !rtiStrobe && candFound && (higherOk || sameOk);
    strobes.selfNest = strobes.take && !higherOk && sameOk;
    strobes.rti      = rtiStrobe && svcFound;
  end

  // R2: a take always picks a latched level that is unmasked and globally enabled
  a_r2_take_eligible: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |-> (latchQ[takeLvl] && maskIn[takeLvl] && globalEn));

  // R3: a take that is not a re-entry outranks every level in service
  a_r3_preempt_rule: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && !strobes.selfNest) |-> ((pendQ & ((NUM_LEVELS'(1) << takeLvl) - NUM_LEVELS'(1))) == '0 && !pendQ[takeLvl]));

  // R9: a re-entry needs a core-sourced level and the enable
  a_r9_core_only_nest: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selfNest |-> (coreSrc[takeLvl] && selfNestEn && retSaved));

  // R11: return cycle never carries a take
  a_r11_rti_blocks_take: assert property (@(posedge clk) disable iff (!rstN)
    rtiStrobe |-> !strobes.take);
endmodule

// File: rtl/nic_datapath.sv
module nic_datapath
  import nic_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int NEST_MAX = 3,
  parameter int LVL_W = $clog2(NUM_LEVELS),
  parameter int DEPTH_W = $clog2(NEST_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqIn,
  input  ctrlStrobeT            strobes,
  input  logic [LVL_W-1:0]      takeLvl,
  input  logic [LVL_W-1:0]      svcLvl,
  input  logic                  svcFound,
  output logic [NUM_LEVELS-1:0] latchQ,
  output logic [NUM_LEVELS-1:0] pendQ,
  output logic [NUM_LEVELS-1:0] nestFull,
  output logic                  takeOut,
  output logic [LVL_W-1:0]      vecLevel,
  output logic                  selfNestFlag
);
  logic [NUM_LEVELS-1:0]              takeHot;
  logic [NUM_LEVELS-1:0]              svcHot;
  logic [NUM_LEVELS-1:0][DEPTH_W-1:0] depthVec;
  logic                               rtiPop;

  assign takeHot = strobes.take ? (NUM_LEVELS'(1) << takeLvl) : '0;
  assign svcHot  = NUM_LEVELS'(1) << svcLvl;
  assign rtiPop  = strobes.rti && (depthVec[svcLvl] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= '0;
      pendQ    <= '0;
      takeOut  <= 1'b0;
      vecLevel <= '0;
    end else begin
      latchQ  <= (latchQ & ~takeHot) | reqIn;
      takeOut <= strobes.take;
      if (strobes.take) begin
        pendQ    <= pendQ | takeHot;
        vecLevel <= takeLvl;
      end else if (rtiPop) begin
        pendQ <= pendQ & ~svcHot;
      end
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLevel
    logic [DEPTH_W-1:0] depthR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        depthR <= '0;
      end else if (strobes.take && strobes.selfNest && (takeLvl == LVL_W'(g))) begin
        depthR <= depthR + DEPTH_W'(1);
      end else if (strobes.rti && (svcLvl == LVL_W'(g)) && (depthR != '0)) begin
        depthR <= depthR - DEPTH_W'(1);
      end
    end
    assign depthVec[g] = depthR;
    assign nestFull[g] = (depthR == DEPTH_W'(NEST_MAX));

    // R10: nesting count never passes its cap
    a_r10_depth_cap: assert property (@(posedge clk) disable iff (!rstN)
      depthR <= DEPTH_W'(NEST_MAX));
  end

  assign selfNestFlag = svcFound && (depthVec[svcLvl] != '0);

  // R4: a take leaves its level in service and raises the strobe
  a_r4_take_sets_pend: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (takeOut && pendQ[vecLevel]));

  // R12: in-service bits drop only after a return strobe
  a_r12_pend_drop_needs_rti: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rti |=> ((~pendQ & $past(pendQ)) == '0));
endmodule

// File: rtl/nic_top.sv
module nic_top
  import nic_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int NEST_MAX = 3,
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam int DEPTH_W = $clog2(NEST_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqIn,
  input  logic [NUM_LEVELS-1:0] maskIn,
  input  logic [NUM_LEVELS-1:0] coreSrc,
  input  logic                  globalEn,
  input  logic                  selfNestEn,
  input  logic                  retSaved,
  input  logic                  rtiStrobe,
  output logic                  takeOut,
  output logic [LVL_W-1:0]      vecLevel,
  output logic [NUM_LEVELS-1:0] latchOut,
  output logic [NUM_LEVELS-1:0] pendOut,
  output logic                  selfNestFlag
);
  ctrlStrobeT            strobes;
  logic [LVL_W-1:0]      takeLvl;
  logic [LVL_W-1:0]      svcLvl;
  logic                  svcFound;
  logic [NUM_LEVELS-1:0] latchQ;
  logic [NUM_LEVELS-1:0] pendQ;
  logic [NUM_LEVELS-1:0] nestFull;

  nic_control #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .latchQ(latchQ), .pendQ(pendQ), .nestFull(nestFull),
    .maskIn(maskIn), .coreSrc(coreSrc), .globalEn(globalEn), .selfNestEn(selfNestEn),
    .retSaved(retSaved), .rtiStrobe(rtiStrobe), .strobes(strobes),
    .takeLvl(takeLvl), .svcLvl(svcLvl), .svcFound(svcFound)
  );

  nic_datapath #(.NUM_LEVELS(NUM_LEVELS), .NEST_MAX(NEST_MAX), .LVL_W(LVL_W),
                 .DEPTH_W(DEPTH_W)) uData (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strobes(strobes), .takeLvl(takeLvl),
    .svcLvl(svcLvl), .svcFound(svcFound), .latchQ(latchQ), .pendQ(pendQ),
    .nestFull(nestFull), .takeOut(takeOut), .vecLevel(vecLevel),
    .selfNestFlag(selfNestFlag)
  );

  assign latchOut = latchQ;
  assign pendOut  = pendQ;
endmodule

// File: tb/tb_nic_top.sv
`timescale 1ns/1ps
module tb_nic_top;
  localparam int N = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqIn, maskIn, coreSrc;
  logic          globalEn, selfNestEn, retSaved, rtiStrobe;
  logic          takeOut;
  logic [LW-1:0] vecLevel;
  logic [N-1:0]  latchOut, pendOut;
  logic          selfNestFlag;

  int total = 0;
  int bad = 0;
  int expQ[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  nic_top #(.NUM_LEVELS(N), .NEST_MAX(2)) dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .maskIn(maskIn), .coreSrc(coreSrc),
    .globalEn(globalEn), .selfNestEn(selfNestEn), .retSaved(retSaved),
    .rtiStrobe(rtiStrobe), .takeOut(takeOut), .vecLevel(vecLevel),
    .latchOut(latchOut), .pendOut(pendOut), .selfNestFlag(selfNestFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic req(input int lvl);
    reqIn[lvl] = 1'b1;
    step();
    reqIn = '0;
  endtask

  task automatic rti();
    rtiStrobe = 1'b1;
    step();
    rtiStrobe = 1'b0;
  endtask

  // scoreboard monitor: every take is matched against the expected queue
  always @(negedge clk) begin
    int e;
    #1;
    if (rstN && takeOut) begin
      if (expQ.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R2 unexpected take actual=0x%0h expected=none", vecLevel);
      end else begin
        e = expQ.pop_front();
        check(vecLevel == LW'(e), "R2 take level", 32'(vecLevel), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqIn = '0; maskIn = '1; coreSrc = 16'h00FF;
    globalEn = 1'b1; selfNestEn = 1'b0; retSaved = 1'b0; rtiStrobe = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    check(pendOut == 0 && latchOut == 0, "R1 reset regs", {latchOut, pendOut}, 0);
    check(!takeOut && !selfNestFlag, "R1 reset strobes", {takeOut, selfNestFlag}, 0);

    // R4 single entry at level 7
    req(7); expQ.push_back(7); step();
    check(pendOut == 16'h0080, "R4 pend after take", pendOut, 16'h0080);
    check(latchOut == 0, "R4 latch cleared", latchOut, 0);

    // R5 same level without self-nesting waits for return
    req(7);
    step(); step();
    check(latchOut == 16'h0080 && !takeOut, "R5 held latched", latchOut, 16'h0080);
    rti(); expQ.push_back(7); step();
    check(pendOut == 16'h0080 && latchOut == 0, "R5 retaken after return", pendOut, 16'h0080);
    rti();

    // R3 preemption by higher level, lower level waits
    req(7); expQ.push_back(7); step();
    req(3); expQ.push_back(3); step();
    check(pendOut == 16'h0088, "R3 nested pend", pendOut, 16'h0088);
    req(9); step(); step();
    check(latchOut == 16'h0200 && pendOut == 16'h0088, "R3 lower waits", latchOut, 16'h0200);
    rti();
    check(pendOut == 16'h0080, "R12 lowest index cleared", pendOut, 16'h0080);
    step();
    check(latchOut == 16'h0200, "R3 still waits under 7", latchOut, 16'h0200);
    rti(); expQ.push_back(9); step();
    check(pendOut == 16'h0200, "R3 lower taken when free", pendOut, 16'h0200);
    rti(); step();

    // R2 simultaneous requests
    reqIn[5] = 1'b1; reqIn[2] = 1'b1; step(); reqIn = '0;
    expQ.push_back(2); step();
    check(pendOut == 16'h0004 && latchOut == 16'h0020, "R2 lowest wins", pendOut, 16'h0004);
    rti(); expQ.push_back(5); step();
    check(pendOut == 16'h0020, "R2 loser taken later", pendOut, 16'h0020);
    rti(); step();

    // R6 mask and global enable
    maskIn[4] = 1'b0; req(4); step(); step();
    check(latchOut == 16'h0010 && pendOut == 0, "R6 masked held", latchOut, 16'h0010);
    maskIn[4] = 1'b1; expQ.push_back(4); step();
    check(pendOut == 16'h0010, "R6 taken after unmask", pendOut, 16'h0010);
    rti(); step();
    globalEn = 1'b0; req(1); step(); step();
    check(latchOut == 16'h0002 && pendOut == 0, "R6 global disable held", latchOut, 16'h0002);
    globalEn = 1'b1; expQ.push_back(1); step();
    check(pendOut == 16'h0002, "R6 taken after enable", pendOut, 16'h0002);
    rti(); step();

    // R7 / R8 self-nesting on core level 6
    selfNestEn = 1'b1; retSaved = 1'b1;
    req(6); expQ.push_back(6); step();
    check(!selfNestFlag, "R7 first entry not nested", selfNestFlag, 0);
    req(6); expQ.push_back(6); step();
    check(pendOut == 16'h0040 && selfNestFlag, "R7 re-entry flag", {selfNestFlag, pendOut}, 17'h10040);
    rti();
    check(pendOut == 16'h0040 && !selfNestFlag, "R8 inner return keeps pend", {selfNestFlag, pendOut}, 16'h0040);
    rti();
    check(pendOut == 0, "R8 outer return clears", pendOut, 0);

    // R7 gated by saved return address
    req(6); expQ.push_back(6); step();
    retSaved = 1'b0; req(6); step(); step();
    check(latchOut == 16'h0040 && !selfNestFlag, "R7 no re-entry unsaved", latchOut, 16'h0040);
    retSaved = 1'b1; expQ.push_back(6); step();
    check(selfNestFlag && latchOut == 0, "R7 re-entry after save", selfNestFlag, 1);
    rti(); rti();
    check(pendOut == 0, "R8 both returns", pendOut, 0);

    // R9 peripheral level 10 never re-enters
    req(10); expQ.push_back(10); step();
    req(10); step(); step();
    check(latchOut == 16'h0400 && pendOut == 16'h0400 && !selfNestFlag, "R9 peripheral held",
          latchOut, 16'h0400);
    rti(); expQ.push_back(10); step();
    check(pendOut == 16'h0400, "R9 taken after return", pendOut, 16'h0400);
    rti(); step();

    // R10 saturation at NEST_MAX = 2
    req(6); expQ.push_back(6); step();
    req(6); expQ.push_back(6); step();
    req(6); expQ.push_back(6); step();
    check(selfNestFlag && pendOut == 16'h0040, "R10 at cap", pendOut, 16'h0040);
    req(6); step(); step();
    check(latchOut == 16'h0040 && !takeOut, "R10 capped held", latchOut, 16'h0040);
    rti(); expQ.push_back(6); step();
    check(latchOut == 0, "R10 released after return", latchOut, 0);
    rti(); rti();
    check(pendOut == 16'h0040, "R8 count unwinding", pendOut, 16'h0040);
    rti();
    check(pendOut == 0, "R10 fully unwound", pendOut, 0);

    // R11 return cycle blocks a take
    selfNestEn = 1'b0;
    req(7); expQ.push_back(7); step();
    maskIn[3] = 1'b0; req(3);
    check(latchOut == 16'h0008, "R11 setup latch", latchOut, 16'h0008);
    maskIn[3] = 1'b1; rtiStrobe = 1'b1; step(); rtiStrobe = 1'b0;
    check(!takeOut && pendOut == 0, "R11 no take on return cycle", {takeOut, pendOut}, 0);
    expQ.push_back(3); step();
    check(takeOut && pendOut == 16'h0008, "R11 take next cycle", pendOut, 16'h0008);
    rti(); step();

    // R12 return with nothing in service
    rti(); step();
    check(pendOut == 0 && latchOut == 0 && !takeOut && !selfNestFlag, "R12 idle return ignored",
          {latchOut, pendOut}, 0);

    repeat (3) step();
    check(expQ.size() == 0, "R2 all expected takes seen", expQ.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule